// File: doc/BRIEF.md
# Bulk IN Endpoint Interrupt Status

This block keeps the interrupt status byte for one bulk IN endpoint of a USB function controller. Two one-cycle event strobes come in from the protocol engine. The first marks an IN token that was answered with NAK. The second marks a swap of the double-buffered transmit FIFO, after which the CPU may load the next packet. A zero-length packet swap counts as a swap.

Firmware reads the byte over a small CPU bus port to find out why the interrupt fired. It clears bits in two ways. It can write zeros into a separate clear location. The FIFO-swap bit also clears by itself on the next CPU write into the endpoint data FIFO. The block raises a one-cycle interrupt pulse whenever the byte changes value. While the endpoint is disabled, both bits are held at zero.

Top module: `ep_irq_status`

## Requirements
- R1: After reset the status byte reads 0x00 and `irq_o` is low.
- R2: Only bit 5 (NAK flag) and bit 4 (swap flag) are implemented. Bits 7, 6 and 3..0 of the status byte always read 0.
- R3: When `ep_en_i` is high, a high `nak_evt_i` at a rising edge sets bit 5. The bit reads 1 from that edge on.
- R4: When `ep_en_i` is high, a high `tgl_evt_i` at a rising edge sets bit 4. A swap caused by a zero-length packet uses the same strobe.
- R5: A CPU write to the FIFO address (`bus_addr_i` = `FIFO_ADDR`, `bus_wr_i` = 1) clears bit 4 at that edge and leaves bit 5 unchanged.
- R6: A CPU write to the clear address (`CLR_ADDR`) clears each status bit whose matching data bit is 0. Status bits whose data bit is 1 are left unchanged.
- R7: A CPU write to the status address (`STAT_ADDR`) changes nothing.
- R8: While `ep_en_i` is low, both bits go to 0 at the next edge, and events are ignored.
- R9: If a set event and a clear action hit the same bit in the same cycle, the bit ends up set.
- R10: `irq_o` is high for exactly the one cycle after an edge at which the status byte changed value. It stays low when an action leaves the byte unchanged.
- R11: `bus_rdata_o` returns the status byte when `bus_addr_i` equals `STAT_ADDR`, and returns 0x00 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ep_en_i | input | 1 | Endpoint enabled (synchronous) |
| nak_evt_i | input | 1 | Strobe: IN token answered with NAK |
| tgl_evt_i | input | 1 | Strobe: transmit FIFO buffer swapped |
| bus_addr_i | input | ADDR_W | CPU bus address |
| bus_wr_i | input | 1 | CPU write strobe |
| bus_wdata_i | input | 8 | CPU write data |
| bus_rdata_o | output | 8 | CPU read data (combinational) |
| irq_o | output | 1 | Interrupt pulse on status change |

## Verification
The bench builds the block with its default parameters. These are an 8-bit address, status at 0x10, clear at 0x11, FIFO at 0x18, and the flags at bits 5 and 4. With these values, every address the decoder distinguishes can be driven, as can an address it does not decode. Each bit position that the clear mask and the read-back must treat separately can also be checked on its own. Because every event and bus action lands at its own edge, the bench can test the following: the exact interrupt pulse cycle, a same-cycle conflict between set and clear, and the behaviour of the bits across an endpoint disable.

// File: rtl/ep_stat_pkg.sv
package ep_stat_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_STAT = 2'd1,
    OP_CLR  = 2'd2,
    OP_FIFO = 2'd3
  } bus_op_e;
endpackage

// File: rtl/ep_bus_dec.sv
module ep_bus_dec
  import ep_stat_pkg::*;
#(
  parameter int unsigned         ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]   STAT_ADDR = 'h10,
  parameter logic [ADDR_W-1:0]   CLR_ADDR  = 'h11,
  parameter logic [ADDR_W-1:0]   FIFO_ADDR = 'h18
) (
  input  logic [ADDR_W-1:0] addr_i,
  output bus_op_e           op_o
);
  always_comb begin
    op_o = OP_NONE;
    if (addr_i == STAT_ADDR)      op_o = OP_STAT;
    else if (addr_i == CLR_ADDR)  op_o = OP_CLR;
    else if (addr_i == FIFO_ADDR) op_o = OP_FIFO;
  end
endmodule

// File: rtl/ep_stat_cell.sv
module ep_stat_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (!en_i)  q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;   // set beats clear
    else if (clr_i)  q_o <= 1'b0;
  end

  // R9
  set_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && set_i |=> q_o);
  // R8
  dis_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !q_o);
endmodule

// File: rtl/ep_chg_irq.sv
module ep_chg_irq #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cur_i,
  output logic         irq_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= cur_i;
  end

  assign irq_o = |(cur_i ^ prev_q);
endmodule

// File: rtl/ep_irq_status.sv
module ep_irq_status
  import ep_stat_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h10,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 'h11,
  parameter logic [ADDR_W-1:0] FIFO_ADDR = 'h18,
  parameter int unsigned       NAK_BIT   = 5,
  parameter int unsigned       TGL_BIT   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ep_en_i,
  input  logic              nak_evt_i,
  input  logic              tgl_evt_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic              irq_o
);
  localparam int unsigned NFLAG = 2;
  localparam int unsigned BIT_POS [NFLAG] = '{NAK_BIT, TGL_BIT};
  localparam logic [7:0]  IMPL_MASK = (8'h1 << NAK_BIT) | (8'h1 << TGL_BIT);

  bus_op_e           op;
  logic              clr_wr, fifo_wr;
  logic [NFLAG-1:0]  set_v, clr_v, q_v;
  logic [7:0]        stat;

  ep_bus_dec #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR),
    .CLR_ADDR(CLR_ADDR), .FIFO_ADDR(FIFO_ADDR)
  ) u_dec (
    .addr_i(bus_addr_i),
    .op_o  (op)
  );

  assign clr_wr  = bus_wr_i && (op == OP_CLR);
  assign fifo_wr = bus_wr_i && (op == OP_FIFO);
  assign set_v   = {tgl_evt_i, nak_evt_i};

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    // flag 1 (swap) also clears on the FIFO write
    if (i == 1) begin : g_auto
      assign clr_v[i] = (clr_wr && !bus_wdata_i[BIT_POS[i]]) || fifo_wr;
    end else begin : g_man
      assign clr_v[i] = clr_wr && !bus_wdata_i[BIT_POS[i]];
    end
    ep_stat_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (ep_en_i),
      .set_i (set_v[i]),
      .clr_i (clr_v[i]),
      .q_o   (q_v[i])
    );
  end

  always_comb begin
    stat          = '0;
    stat[NAK_BIT] = q_v[0];
    stat[TGL_BIT] = q_v[1];
  end

  ep_chg_irq #(.W(8)) u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cur_i (stat),
    .irq_o (irq_o)
  );

  assign bus_rdata_o = (op == OP_STAT) ? stat : 8'h00;

  // R2
  always_comb begin
    unused_zero_chk: assert ((bus_rdata_o & ~IMPL_MASK) == 8'h00);
  end

  // R10
  irq_on_nak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ep_en_i && nak_evt_i && !stat[NAK_BIT] |=> irq_o);
  // R5
  fifo_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr && !tgl_evt_i |=> !stat[TGL_BIT]);
  // R7
  ro_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ep_en_i && bus_wr_i && op == OP_STAT && !nak_evt_i && !tgl_evt_i
    |=> $stable(stat));
endmodule

// File: tb/tb_ep_irq_status.sv
module tb_ep_irq_status;
  localparam logic [7:0] A_STAT = 8'h10, A_CLR = 8'h11, A_FIFO = 8'h18, A_NONE = 8'h33;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       en = 1'b0, nak = 1'b0, tgl = 1'b0, wr = 1'b0;
  logic [7:0] addr = A_STAT, wdata = 8'h00, rdata;
  logic       irq;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  ep_irq_status dut (
    .clk_i(clk), .rst_ni(rst_n), .ep_en_i(en), .nak_evt_i(nak),
    .tgl_evt_i(tgl), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one edge with the given stimulus; returns just before the following edge
  task automatic step(logic e_nak, logic e_tgl, logic w, logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    nak = e_nak; tgl = e_tgl; wr = w; addr = a; wdata = d;
    @(negedge clk);
    nak = 1'b0; tgl = 1'b0; wr = 1'b0; addr = A_STAT; wdata = 8'h00;
    #0.5;
  endtask

  task automatic rd(string req, logic [7:0] exp);
    addr = A_STAT; #0.5;
    chk(req, rdata, exp);
  endtask

  task automatic idle_irq(string req, logic exp);
    chk(req, {7'd0, irq}, {7'd0, exp});
  endtask

  task automatic t_reset;
    rd("R1 reset byte", 8'h00);
    idle_irq("R1 reset irq", 1'b0);
  endtask

  task automatic t_nak;
    step(1, 0, 0, A_STAT, 0);
    rd("R3 nak sets bit5", 8'h20);
    idle_irq("R10 irq after nak", 1'b1);
    @(negedge clk); #0.5;
    idle_irq("R10 irq one cycle", 1'b0);
    step(1, 0, 0, A_STAT, 0);
    idle_irq("R10 no irq on repeat set", 1'b0);
    addr = A_NONE; #0.5;
    chk("R11 other addr reads 0", rdata, 8'h00);
  endtask

  task automatic t_tgl_fifo;
    step(0, 1, 0, A_STAT, 0);
    rd("R4 swap sets bit4", 8'h30);
    rd("R2 unused bits zero", 8'h30 & 8'h30);
    chk("R2 mask", rdata & 8'hCF, 8'h00);
    step(0, 1, 0, A_STAT, 0);  // zero-length swap, bit already set
    rd("R4 zlp swap keeps bit4", 8'h30);
    step(0, 0, 1, A_FIFO, 8'hFF);
    rd("R5 fifo write clears bit4 only", 8'h20);
    idle_irq("R10 irq on auto clear", 1'b1);
    step(0, 0, 1, A_FIFO, 8'h00);
    rd("R5 second fifo write", 8'h20);
    idle_irq("R10 no irq unchanged", 1'b0);
  endtask

  task automatic t_clear;
    step(0, 1, 0, A_STAT, 0);
    rd("R4 set again", 8'h30);
    step(0, 0, 1, A_CLR, 8'hDF);
    rd("R6 clear bit5 only", 8'h10);
    step(0, 0, 1, A_CLR, 8'hFF);
    rd("R6 ones leave bits", 8'h10);
    idle_irq("R10 no irq on ones", 1'b0);
    step(0, 0, 1, A_STAT, 8'h00);
    rd("R7 status write ignored", 8'h10);
    step(0, 0, 1, A_CLR, 8'hEF);
    rd("R6 clear bit4", 8'h00);
  endtask

  task automatic t_prio;
    step(1, 0, 1, A_CLR, 8'h00);
    rd("R9 nak set beats clear", 8'h20);
    step(0, 1, 1, A_FIFO, 8'h00);
    rd("R9 swap set beats fifo write", 8'h30);
  endtask

  task automatic t_disable;
    @(negedge clk); en = 1'b0;
    @(negedge clk); #0.5;
    rd("R8 disable clears", 8'h00);
    idle_irq("R10 irq on disable clear", 1'b1);
    step(1, 1, 0, A_STAT, 0);
    rd("R8 events ignored", 8'h00);
    @(negedge clk); en = 1'b1;
    step(1, 0, 0, A_STAT, 0);
    rd("R3 works after re-enable", 8'h20);
  endtask

  initial begin
    #9 rst_n = 1'b1;
    @(negedge clk); #0.5;
    t_reset();
    en = 1'b1;
    t_nak();
    t_tgl_fifo();
    t_clear();
    t_prio();
    t_disable();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule